// File: doc/BRIEF.md
# FIFO Fill-Level Request Generator

This block watches the fill counts of the receive and transmit FIFOs of an audio serial port. From these counts it raises three request lines: one interrupt request and two separate DMA request lines. Each FIFO holds 8 words of 32 bits, so each fill count runs from 0 to 8 on a 4-bit bus.

Every request line has its own receive enable, transmit enable, receive threshold and transmit threshold. The receive side asks for service once enough words have arrived, so the FIFO can be drained. The transmit side asks for service once the FIFO has emptied far enough, so it can be refilled. A line is raised when either of its enabled conditions holds. All requests are level-sensitive and registered. A packed status word gives software the request states and both fill counts, sampled in the same cycle as the requests.

Top module: `fifo_req_gen`

## Requirements
- R1: While `rst_n` is low, `irq`, `dmareq1`, `dmareq2` and the whole of `status` are 0. This holds whatever the inputs are.
- R2: The receive condition of a source is true when its `rx_en` bit is 1 and `rx_level` is greater than or equal to its receive threshold. With a threshold of 0, the condition is true at every level.
- R3: The transmit condition of a source is true when its `tx_en` bit is 1 and `tx_level` is less than or equal to its transmit threshold. With a threshold of 0, the condition is true only when the level is 0.
- R4: Each request output is the OR of its receive condition and its transmit condition.
- R5: A direction whose enable bit is 0 has no effect on the request, whatever its level and threshold are.
- R6: A request reflects the inputs sampled at the previous rising clock edge. It rises one cycle after its condition becomes true and falls one cycle after the condition clears.
- R7: The three sources are independent. Source index 0 drives `irq`, index 1 drives `dmareq1` and index 2 drives `dmareq2`. Source s uses enable bit s and the threshold fields at bits [4s+3:4s].
- R8: The layout of `status` is as follows. Bit 0 is `irq`, bit 1 is `dmareq1` and bit 2 is `dmareq2`. Bits 11:8 hold the registered receive level and bits 19:16 hold the registered transmit level. Every other bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_level | input | 4 | Receive FIFO fill count |
| tx_level | input | 4 | Transmit FIFO fill count |
| rx_en | input | 3 | Receive enable per source (0 irq, 1 dma1, 2 dma2) |
| tx_en | input | 3 | Transmit enable per source |
| rx_thr | input | 12 | Receive thresholds, 4 bits per source |
| tx_thr | input | 12 | Transmit thresholds, 4 bits per source |
| irq | output | 1 | Interrupt request |
| dmareq1 | output | 1 | First DMA request |
| dmareq2 | output | 1 | Second DMA request |
| status | output | 32 | Packed requests and fill counts |

## Verification
The assertions check three things on every clock cycle for each source. A met receive condition or a met transmit condition is followed by a raised request. A cycle with neither condition is followed by a dropped request. The status word always mirrors the request lines, copies the previous cycle's fill counts and keeps its unused bits at zero. Some behaviours appear only in the bench's scenarios: the reset values, the exact boundary results at and around each threshold, the threshold-zero corner cases, and the fact that one shared level can set some sources while leaving others clear.

// File: rtl/fifo_req_gen.sv
module fifo_req_gen #(
  parameter int LVL_W = 4,
  localparam int NSRC = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LVL_W-1:0]        rx_level,
  input  logic [LVL_W-1:0]        tx_level,
  input  logic [NSRC-1:0]         rx_en,
  input  logic [NSRC-1:0]         tx_en,
  input  logic [NSRC*LVL_W-1:0]   rx_thr,
  input  logic [NSRC*LVL_W-1:0]   tx_thr,
  output logic                    irq,
  output logic                    dmareq1,
  output logic                    dmareq2,
  output logic [31:0]             status
);

  localparam int RXF_LSB = 8;
  localparam int TXF_LSB = 16;

  logic [NSRC-1:0]  hit;
  logic [NSRC-1:0]  req_q;
  logic [LVL_W-1:0] rx_q, tx_q;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic [LVL_W-1:0] rt, tt;
    logic             rx_hit, tx_hit;
    assign rt     = rx_thr[s*LVL_W +: LVL_W];
    assign tt     = tx_thr[s*LVL_W +: LVL_W];
    assign rx_hit = rx_en[s] && (rx_level >= rt);
    assign tx_hit = tx_en[s] && (tx_level <= tt);
    assign hit[s] = rx_hit || tx_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      rx_q  <= '0;
      tx_q  <= '0;
    end else begin
      req_q <= hit;
      rx_q  <= rx_level;
      tx_q  <= tx_level;
    end
  end

  assign irq     = req_q[0];
  assign dmareq1 = req_q[1];
  assign dmareq2 = req_q[2];

  always_comb begin
    status                      = '0;
    status[NSRC-1:0]            = req_q;
    status[RXF_LSB +: LVL_W]    = rx_q;
    status[TXF_LSB +: LVL_W]    = tx_q;
  end

endmodule

module fifo_req_gen_chk #(
  parameter int LVL_W = 4,
  localparam int NSRC = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [LVL_W-1:0]      rx_level,
  input logic [LVL_W-1:0]      tx_level,
  input logic [NSRC-1:0]       rx_en,
  input logic [NSRC-1:0]       tx_en,
  input logic [NSRC*LVL_W-1:0] rx_thr,
  input logic [NSRC*LVL_W-1:0] tx_thr,
  input logic                  irq,
  input logic                  dmareq1,
  input logic                  dmareq2,
  input logic [31:0]           status
);

  localparam logic [31:0] FMASK = (32'(1) << LVL_W) - 32'(1);
  localparam logic [31:0] RSV   = ~(32'h7 | (FMASK << 8) | (FMASK << 16));

  logic [NSRC-1:0] outs;
  assign outs = {dmareq2, dmareq1, irq};

  for (genvar s = 0; s < NSRC; s++) begin : g_chk
    assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en[s] && rx_level >= rx_thr[s*LVL_W +: LVL_W]) |=> outs[s])
      else $error("assert_rx_sets_R2 source %0d", s);

    assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en[s] && tx_level <= tx_thr[s*LVL_W +: LVL_W]) |=> outs[s])
      else $error("assert_tx_sets_R3 source %0d", s);

    assert property (@(posedge clk) disable iff (!rst_n)
      (!(rx_en[s] && rx_level >= rx_thr[s*LVL_W +: LVL_W]) &&
       !(tx_en[s] && tx_level <= tx_thr[s*LVL_W +: LVL_W])) |=> !outs[s])
      else $error("assert_clears_next_R6 source %0d", s);
  end

  assert property (@(posedge clk) disable iff (!rst_n)
    status[2:0] == outs)
    else $error("assert_status_reqs_R8");

  assert property (@(posedge clk) disable iff (!rst_n)
    (status & RSV) == 32'h0)
    else $error("assert_status_reserved_R8");

  assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status[8 +: LVL_W] == $past(rx_level) &&
              status[16 +: LVL_W] == $past(tx_level)))
    else $error("assert_status_levels_R8");

endmodule

bind fifo_req_gen fifo_req_gen_chk #(.LVL_W(LVL_W)) u_chk (.*);

// File: tb/test_fifo_req_gen.sv
`timescale 1ns/1ps
module test_fifo_req_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rx_level = '0, tx_level = '0;
  logic [2:0]  rx_en = '0, tx_en = '0;
  logic [11:0] rx_thr = '0, tx_thr = '0;
  logic        irq, dmareq1, dmareq2;
  logic [31:0] status;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  fifo_req_gen i_fifo_req_gen (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .tx_level(tx_level),
    .rx_en(rx_en), .tx_en(tx_en), .rx_thr(rx_thr), .tx_thr(tx_thr),
    .irq(irq), .dmareq1(dmareq1), .dmareq2(dmareq2), .status(status)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FIFO-REQ FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg(int s, bit re, bit te, logic [3:0] rt, logic [3:0] tt);
    rx_en[s] = re;
    tx_en[s] = te;
    rx_thr[s*4 +: 4] = rt;
    tx_thr[s*4 +: 4] = tt;
  endtask

  task automatic clear_cfg();
    rx_en = '0; tx_en = '0; rx_thr = '0; tx_thr = '0;
  endtask

  task automatic levels(logic [3:0] rl, logic [3:0] tl);
    rx_level = rl;
    tx_level = tl;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [2:0] reqs();
    return {dmareq2, dmareq1, irq};
  endfunction

  task automatic t_reset();
    @(negedge clk);
    cfg(0, 1, 1, 4'd0, 4'd8); cfg(1, 1, 1, 4'd0, 4'd8); cfg(2, 1, 1, 4'd0, 4'd8);
    rx_level = 4'd5; tx_level = 4'd3;
    repeat (2) @(negedge clk);
    check("R1 reqs in reset", 32'(reqs()), 32'h0);
    check("R1 status in reset", status, 32'h0);
    clear_cfg();
    rx_level = 0; tx_level = 0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_rx_threshold();
    clear_cfg();
    cfg(0, 1, 0, 4'd5, 4'd0);
    levels(4'd4, 4'd0); check("R2 rx below thr", 32'(irq), 32'h0);
    levels(4'd5, 4'd0); check("R2 rx at thr", 32'(irq), 32'h1);
    levels(4'd8, 4'd0); check("R2 rx full", 32'(irq), 32'h1);
    cfg(0, 1, 0, 4'd0, 4'd0);
    levels(4'd0, 4'd0); check("R2 rx thr zero", 32'(irq), 32'h1);
  endtask

  task automatic t_tx_threshold();
    clear_cfg();
    cfg(1, 0, 1, 4'd0, 4'd2);
    levels(4'd0, 4'd3); check("R3 tx above thr", 32'(dmareq1), 32'h0);
    levels(4'd0, 4'd2); check("R3 tx at thr", 32'(dmareq1), 32'h1);
    levels(4'd0, 4'd0); check("R3 tx empty", 32'(dmareq1), 32'h1);
    cfg(1, 0, 1, 4'd0, 4'd0);
    levels(4'd0, 4'd1); check("R3 tx thr zero level one", 32'(dmareq1), 32'h0);
    levels(4'd0, 4'd0); check("R3 tx thr zero level zero", 32'(dmareq1), 32'h1);
  endtask

  task automatic t_or();
    clear_cfg();
    cfg(2, 1, 1, 4'd6, 4'd1);
    levels(4'd6, 4'd5); check("R4 rx only", 32'(dmareq2), 32'h1);
    levels(4'd2, 4'd1); check("R4 tx only", 32'(dmareq2), 32'h1);
    levels(4'd7, 4'd0); check("R4 both", 32'(dmareq2), 32'h1);
    levels(4'd2, 4'd5); check("R4 neither", 32'(dmareq2), 32'h0);
  endtask

  task automatic t_disable();
    clear_cfg();
    cfg(0, 0, 0, 4'd0, 4'd8); cfg(1, 0, 0, 4'd0, 4'd8); cfg(2, 0, 0, 4'd0, 4'd8);
    levels(4'd8, 4'd0); check("R5 all disabled", 32'(reqs()), 32'h0);
    cfg(1, 0, 1, 4'd0, 4'd0);
    levels(4'd8, 4'd4); check("R5 rx disabled tx unmet", 32'(dmareq1), 32'h0);
  endtask

  task automatic t_latency();
    clear_cfg();
    cfg(0, 1, 0, 4'd3, 4'd0);
    levels(4'd0, 4'd8);
    check("R6 idle", 32'(irq), 32'h0);
    rx_level = 4'd3;
    #1;
    check("R6 no change before edge", 32'(irq), 32'h0);
    @(posedge clk); #1;
    check("R6 rises after one edge", 32'(irq), 32'h1);
    @(negedge clk);
    rx_level = 4'd2;
    #1;
    check("R6 holds before edge", 32'(irq), 32'h1);
    @(posedge clk); #1;
    check("R6 falls after one edge", 32'(irq), 32'h0);
    @(negedge clk);
  endtask

  task automatic t_independent();
    clear_cfg();
    cfg(0, 1, 0, 4'd4, 4'd0);
    cfg(1, 1, 0, 4'd7, 4'd0);
    cfg(2, 0, 1, 4'd0, 4'd6);
    levels(4'd5, 4'd6); check("R7 mixed sources", 32'(reqs()), 32'b101);
    levels(4'd7, 4'd7); check("R7 mixed sources 2", 32'(reqs()), 32'b011);
  endtask

  task automatic t_status();
    clear_cfg();
    cfg(1, 0, 1, 4'd0, 4'd5);
    levels(4'd6, 4'd3);
    check("R8 status word", status, 32'h0003_0602);
    cfg(0, 1, 0, 4'd8, 4'd0); cfg(2, 1, 0, 4'd1, 4'd0);
    levels(4'd8, 4'd8);
    check("R8 status full", status, 32'h0008_0805);
  endtask

  initial begin
    t_reset();
    t_rx_threshold();
    t_tx_threshold();
    t_or();
    t_disable();
    t_latency();
    t_independent();
    t_status();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FIFO-REQ FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule